// File: doc/BRIEF.md
# Parallel LED Status Scanner

This block drives a bank of status LEDs from one shared 8-bit output. Ten status bytes take turns on it: eight per-port status bytes that the switch core supplies on a flat input bus, then two bytes that software writes. A 10-bit select output has exactly one bit high, and that bit names the byte now on the output, so board logic can latch each byte into the right LED group. The byte output is active low: a status bit at 1 pulls its pin to 0.

The scan runs without pause once reset has been released. A pulse from an external rate divider (`scan_en`) steps it by one slot per clock. A small write-only register port holds the two software bytes. The same port also holds per-pin polarity settings for output pins 2 to 6. An inverted pin shows the opposite level of its status bit.

Top module: `led_par_scan`

## Requirements
- R1: While `rst_n` is low, and for the first clock edge after it rises, `led_sel` is all zeros and `led_byte_n` is 8'hFF.
- R2: From the second rising edge after `rst_n` rises, `led_sel` is 10'h001 (slot 0) until the first cycle in which `scan_en` is high.
- R3: After reset release, `led_sel` has exactly one bit set, and it stays nonzero until reset is asserted again.
- R4: On each rising edge with `scan_en` high, the slot advances 0,1,…,9 and then returns to 0. With `scan_en` low, the slot holds.
- R5: In slot k (0–7), `led_byte_n` is the bitwise complement of `port_status[8k+7:8k]`, after any polarity inversion. It follows changes of that input in the same cycle.
- R6: In slots 8 and 9, the byte shown is the content of register address 0 and address 1 respectively. It is complemented like R5.
- R7: A write of `reg_wdata` to address j (2–6) sets the polarity of output pin j from `reg_wdata[3:0]`. 4'h0 means no inversion. Any nonzero value inverts the status bit before the active-low complement. `reg_wdata[7:4]` is ignored.
- R8: Output pins 0, 1 and 7 are never inverted. A write to address 7 changes no output.
- R9: A register write with `reg_wr_en` high at a rising edge is visible on `led_byte_n` from that edge on, including in the middle of a scan and while its slot is being shown.
- R10: Asserting `rst_n` during operation clears the registers and forces `led_sel` to zero at once. After release, the scan restarts at slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_en | input | 1 | Advance pulse from the scan-rate divider |
| port_status | input | 64 | Eight port status bytes, port k in bits [8k+7:8k] |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0–1 user bytes, 2–6 pin polarity, 7 unused |
| reg_wdata | input | 8 | Register write data |
| led_sel | output | 10 | One-hot slot select |
| led_byte_n | output | 8 | Active-low status byte for the selected slot |

## Verification
The hardest case to reach is a register write that lands while its own slot is on the output, or that lands while the scan is moving toward that slot. The output then has to switch in the middle of the byte's display or on the first visit after the write. The bench parks the scan on slot 8 with `scan_en` low, writes address 0, and checks the next sample. It then writes address 1 with `scan_en` high while slot 5 is shown, and follows the scan until slot 9 shows the new value. Polarity settings are also set to a mix of zero, one and upper-nibble-only values before a full loop, so that every pin's inversion rule is tested against live port bytes.

// File: rtl/led_scan_pkg.sv
`timescale 1ns/1ps
package led_scan_pkg;
  localparam int LED_W      = 8;   // pins on the byte output
  localparam int PORT_CNT   = 8;   // port status slots
  localparam int USER_CNT   = 2;   // software byte slots, at addresses 0..USER_CNT-1
  localparam int REG_AW     = 3;   // register address width
  localparam int POL_W      = 4;   // polarity field width
  localparam int CTRL_LAST  = 6;   // last pin with a polarity register
  localparam int SYNC_DEPTH = 2;   // reset release synchronizer stages
endpackage

// File: rtl/led_rst_sync.sv
`timescale 1ns/1ps
module led_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/led_slot_ctr.sv
`timescale 1ns/1ps
module led_slot_ctr #(
  parameter int SLOTS  = 10,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    slot_d = slot_q;
    if (adv) begin
      if (slot_q == LAST) slot_d = '0;
      else                slot_d = slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;
endmodule

// File: rtl/led_cfg_regs.sv
`timescale 1ns/1ps
module led_cfg_regs #(
  parameter int LED_W      = 8,
  parameter int USER_CNT   = 2,
  parameter int REG_AW     = 3,
  parameter int POL_W      = 4,
  parameter int CTRL_LAST  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [REG_AW-1:0]         addr,
  input  logic [LED_W-1:0]          wdata,
  output logic [USER_CNT*LED_W-1:0] user_bytes,
  output logic [LED_W-1:0]          inv_mask
);
  // software bytes at addresses 0..USER_CNT-1
  for (genvar u = 0; u < USER_CNT; u++) begin : g_user
    logic [LED_W-1:0] byte_q;
    logic [LED_W-1:0] byte_d;
    always_comb begin
      byte_d = byte_q;
      if (wr_en && addr == REG_AW'(u)) byte_d = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end
    assign user_bytes[u*LED_W +: LED_W] = byte_q;
  end

  // polarity register for pin p lives at address p; other pins stay true
  for (genvar p = 0; p < LED_W; p++) begin : g_pin
    if (p >= USER_CNT && p <= CTRL_LAST) begin : g_pol
      logic [POL_W-1:0] pol_q;
      logic [POL_W-1:0] pol_d;
      always_comb begin
        pol_d = pol_q;
        if (wr_en && addr == REG_AW'(p)) pol_d = wdata[POL_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q <= '0;
        else        pol_q <= pol_d;
      end
      assign inv_mask[p] = |pol_q;
    end else begin : g_fixed
      assign inv_mask[p] = 1'b0;
    end
  end
endmodule

// File: rtl/led_byte_sel.sv
`timescale 1ns/1ps
module led_byte_sel #(
  parameter int LED_W    = 8,
  parameter int PORT_CNT = 8,
  parameter int USER_CNT = 2,
  localparam int SLOTS   = PORT_CNT + USER_CNT,
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic                      run,
  input  logic [SLOT_W-1:0]         slot,
  input  logic [PORT_CNT*LED_W-1:0] port_bytes,
  input  logic [USER_CNT*LED_W-1:0] user_bytes,
  input  logic [LED_W-1:0]          inv_mask,
  output logic [SLOTS-1:0]          sel,
  output logic [LED_W-1:0]          byte_n
);
  logic [SLOTS*LED_W-1:0] all_bytes;
  logic [LED_W-1:0]       raw;

  assign all_bytes = {user_bytes, port_bytes};

  for (genvar s = 0; s < SLOTS; s++) begin : g_sel
    assign sel[s] = run && (slot == SLOT_W'(s));
  end

  always_comb begin
    raw    = all_bytes[int'(slot)*LED_W +: LED_W];
    byte_n = run ? ~(raw ^ inv_mask) : '1;
  end
endmodule

// File: rtl/led_par_scan.sv
`timescale 1ns/1ps
module led_par_scan
  import led_scan_pkg::*;
#(
  parameter int P_LED_W      = LED_W,
  parameter int P_PORT_CNT   = PORT_CNT,
  parameter int P_USER_CNT   = USER_CNT,
  parameter int P_REG_AW     = REG_AW,
  parameter int P_POL_W      = POL_W,
  parameter int P_CTRL_LAST  = CTRL_LAST,
  parameter int P_SYNC_DEPTH = SYNC_DEPTH,
  localparam int SLOTS       = P_PORT_CNT + P_USER_CNT,
  localparam int SLOT_W      = $clog2(SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scan_en,
  input  logic [P_PORT_CNT*P_LED_W-1:0] port_status,
  input  logic                          reg_wr_en,
  input  logic [P_REG_AW-1:0]           reg_addr,
  input  logic [P_LED_W-1:0]            reg_wdata,
  output logic [SLOTS-1:0]              led_sel,
  output logic [P_LED_W-1:0]            led_byte_n
);
  logic                          run_n;
  logic [SLOT_W-1:0]             slot;
  logic [P_USER_CNT*P_LED_W-1:0] user_bytes;
  logic [P_LED_W-1:0]            inv_mask;

  led_rst_sync #(.STAGES(P_SYNC_DEPTH)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (run_n)
  );

  led_slot_ctr #(.SLOTS(SLOTS)) u_slot_ctr (
    .clk   (clk),
    .rst_n (run_n),
    .adv   (scan_en),
    .slot  (slot)
  );

  led_cfg_regs #(
    .LED_W     (P_LED_W),
    .USER_CNT  (P_USER_CNT),
    .REG_AW    (P_REG_AW),
    .POL_W     (P_POL_W),
    .CTRL_LAST (P_CTRL_LAST)
  ) u_cfg_regs (
    .clk        (clk),
    .rst_n      (run_n),
    .wr_en      (reg_wr_en),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .user_bytes (user_bytes),
    .inv_mask   (inv_mask)
  );

  led_byte_sel #(
    .LED_W    (P_LED_W),
    .PORT_CNT (P_PORT_CNT),
    .USER_CNT (P_USER_CNT)
  ) u_byte_sel (
    .run        (run_n),
    .slot       (slot),
    .port_bytes (port_status),
    .user_bytes (user_bytes),
    .inv_mask   (inv_mask),
    .sel        (led_sel),
    .byte_n     (led_byte_n)
  );
endmodule

// File: rtl/led_par_scan_chk.sv
`timescale 1ns/1ps
module led_par_scan_chk #(
  parameter int SLOTS  = 10,
  parameter int REG_AW = 3,
  parameter int PORTS  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_en,
  input logic [7:0]        port_byte0,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [1:0]        wdata_lo,
  input logic [SLOTS-1:0]  led_sel,
  input logic [7:0]        led_byte_n
);
  // R3: never more than one select bit, and once running it stays running
  assert_sel_onehot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(led_sel));
  assert_sel_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (led_sel != '0) |=> ($countones(led_sel) == 1));

  // R4: step, wrap and hold
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (led_sel != '0 && scan_en && !led_sel[SLOTS-1]) |=> (led_sel == ($past(led_sel) << 1)));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && led_sel[SLOTS-1]) |=> (led_sel == SLOTS'(1)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (led_sel != '0 && !scan_en) |=> $stable(led_sel));

  // R8: pins 0, 1 and 7 carry port 0 status uninverted
  assert_fixed_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    led_sel[0] |-> (led_byte_n[0] == ~port_byte0[0] && led_byte_n[1] == ~port_byte0[1]
                    && led_byte_n[7] == ~port_byte0[7]));

  // R9: a write to address 0 is seen at once on the slot that shows it
  assert_user_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == REG_AW'(0) && led_sel[PORTS-1] && scan_en)
      |=> (led_byte_n[1:0] == ~$past(wdata_lo)));
endmodule

bind led_par_scan led_par_scan_chk #(
  .SLOTS  (SLOTS),
  .REG_AW (P_REG_AW),
  .PORTS  (P_PORT_CNT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_en    (scan_en),
  .port_byte0 (port_status[7:0]),
  .reg_wr_en  (reg_wr_en),
  .reg_addr   (reg_addr),
  .wdata_lo   (reg_wdata[1:0]),
  .led_sel    (led_sel),
  .led_byte_n (led_byte_n)
);

// File: tb/led_par_scan_bench.sv
`timescale 1ns/1ps
module led_par_scan_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scan_en;
  logic [63:0] port_status;
  logic        reg_wr_en;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [9:0]  led_sel;
  logic [7:0]  led_byte_n;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int         m_slot;
  int         m_rel;
  logic [7:0] m_user [2];
  logic [3:0] m_pol  [8];

  always #2 clk = ~clk;

  led_par_scan u_led_par_scan (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .port_status(port_status),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .led_sel(led_sel), .led_byte_n(led_byte_n)
  );

  function automatic logic [7:0] exp_byte();
    logic [7:0] raw;
    logic [7:0] mask;
    if (m_rel < 2) return 8'hFF;
    raw  = (m_slot < 8) ? port_status[m_slot*8 +: 8] : m_user[m_slot-8];
    mask = '0;
    for (int j = 2; j <= 6; j++) mask[j] = (m_pol[j] != 4'h0);
    return ~(raw ^ mask);
  endfunction

  function automatic logic [9:0] exp_sel();
    if (m_rel < 2) return '0;
    return 10'(1) << m_slot;
  endfunction

  task automatic model_clear();
    m_slot = 0; m_rel = 0;
    m_user[0] = '0; m_user[1] = '0;
    for (int j = 0; j < 8; j++) m_pol[j] = '0;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) begin
      if (m_rel >= 2) begin
        if (reg_wr_en) begin
          if (reg_addr < 3'd2) m_user[reg_addr] = reg_wdata;
          else if (reg_addr <= 3'd6) m_pol[reg_addr] = reg_wdata[3:0];
        end
        if (scan_en) m_slot = (m_slot == 9) ? 0 : m_slot + 1;
      end
      if (m_rel < 2) m_rel++;
    end
    #1;
  endtask

  task automatic check_out(string req);
    checks++;
    if (led_sel !== exp_sel() || led_byte_n !== exp_byte()) begin
      fails++;
      $display("FAIL %s sel=%h byte_n=%h expected sel=%h byte_n=%h",
               req, led_sel, led_byte_n, exp_sel(), exp_byte());
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr_en = 1'b0;
  endtask

  // R1 R2: reset state and restart point
  task automatic t_reset();
    rst_n = 1'b0; scan_en = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    port_status = 64'h8877_6655_4433_2211;
    model_clear();
    step(); step();
    check_out("R1 in reset");
    rst_n = 1'b1;
    step();
    check_out("R1 first edge after release");
    step();
    check_out("R2 slot 0 after release");
    step(); step();
    check_out("R2 slot 0 held before scan_en");
  endtask

  // R4 R5 R6: loop order and byte values, more than two rounds
  task automatic t_scan();
    port_status = 64'hF0E1_D2C3_B4A5_9687;
    wr(3'd0, 8'h5A);
    wr(3'd1, 8'hC3);
    check_out("R6 after user writes");
    scan_en = 1'b1;
    for (int i = 0; i < 23; i++) begin
      step();
      check_out("R4 R5 R6 scan loop");
    end
    scan_en = 1'b0;
  endtask

  // R4 hold, R5 live input
  task automatic t_hold();
    scan_en = 1'b1;
    while (m_slot != 3) step();
    scan_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check_out("R4 hold with scan_en low");
    end
    port_status[31:24] = 8'h3C;
    #1;
    check_out("R5 live port byte");
  endtask

  // R7 R8: polarity per pin
  task automatic t_polarity();
    wr(3'd2, 8'h01);
    wr(3'd3, 8'hF0);   // upper nibble only: stays true
    wr(3'd4, 8'h08);
    wr(3'd6, 8'h0F);
    wr(3'd7, 8'hFF);   // no register behind it
    check_out("R7 R8 after polarity writes");
    port_status = 64'hFF00_AA55_0F0F_C381;
    scan_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      check_out("R7 R8 inverted pins loop");
    end
    scan_en = 1'b0;
    wr(3'd5, 8'h02);
    check_out("R7 pin 5 inversion");
    wr(3'd2, 8'h00);
    check_out("R7 pin 2 back to true");
  endtask

  // R9: writes during display and mid-scan
  task automatic t_midscan();
    scan_en = 1'b1;
    while (m_slot != 8) step();
    scan_en = 1'b0;
    wr(3'd0, 8'h96);
    check_out("R9 user 0 update while shown");
    scan_en = 1'b1;
    while (m_slot != 5) step();
    wr(3'd1, 8'h3F);
    check_out("R9 write mid-scan");
    for (int i = 0; i < 6; i++) begin
      step();
      check_out("R9 new user 1 reaches slot 9");
    end
    scan_en = 1'b0;
  endtask

  // R10: reset mid-run
  task automatic t_rerst();
    scan_en = 1'b1;
    while (m_slot != 6) step();
    #1;
    rst_n = 1'b0;
    model_clear();
    #1;
    check_out("R10 async clear of select");
    step();
    rst_n = 1'b1;
    step(); step();
    check_out("R10 restart at slot 0");
    step();
    check_out("R10 first step after restart");
    scan_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_scan();
    t_hold();
    t_polarity();
    t_midscan();
    t_rerst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired sel=%h expected run end", led_sel);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule